// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is a combinational 32-bit shifter. It does logical left, logical right, arithmetic right and rotate right, and it produces the carry-out that a processor's data path writes into its carry flag. The shift amount comes from one of two places: a 5-bit field carried in the instruction word, or the low byte of a register operand. The two sources treat an amount of zero differently. They also differ for amounts of 32 and above.

Alongside the shifted value, the block drives a carry-update strobe. It also drives a carry output. When the strobe is low, the carry output simply repeats the incoming carry, so the flag register can hold its value without extra muxing. Zero and negative indications are derived from the result. The register file and the instruction decoder lie outside this block. They supply the operand, the amount and the operation code.

Top module: `shifter_carry_unit`

## Requirements
- R1: The op code selects the operation: 0 is logical left, 1 is logical right, 2 is arithmetic right, 3 is rotate right. For any amount n from 1 to 31, whether it comes from the immediate field or the register byte, the result is the operand shifted by n. A left shift gives carry = operand bit (32-n). A right shift gives carry = operand bit (n-1). carry_update_o is high in this case.
- R2: Immediate logical left by 0 returns the operand unchanged. carry_update_o is low and carry_o equals carry_i.
- R3: Immediate logical right with field 0 shifts by 32: the result is zero and carry = operand bit 31.
- R4: Immediate arithmetic right with field 0 gives all ones when operand bit 31 is set and zero otherwise. Carry = operand bit 31.
- R5: In register form only bits 7:0 of reg_amt_i set the amount; bits 31:8 have no effect. A register amount of 0 leaves the result equal to the operand, with carry_update_o low, for every op.
- R6: Register logical left by exactly 32 gives zero with carry = operand bit 0. By 33 to 255 it gives zero with carry 0.
- R7: Register logical right by exactly 32 gives zero with carry = operand bit 31. By 33 to 255 it gives zero with carry 0.
- R8: Register arithmetic right by 32 to 255 fills every result bit with operand bit 31. Carry = operand bit 31.
- R9: Register rotate uses the amount modulo 32. If those five bits are nonzero, carry = operand bit (amount mod 32 - 1). If they are zero but the byte is nonzero, the result is the operand, carry = operand bit 31, and carry_update_o is high.
- R10: zero_o is high exactly when the result is all zeros. neg_o equals result bit 31.
- R11: carry_update_o is low only for the no-change cases: immediate left by 0, immediate rotate by 0, and register amount 0. Whenever it is low, carry_o equals carry_i.
- R12: Immediate rotate right by field n from 1 to 31 rotates with carry = operand bit (n-1). Field 0 returns the operand unchanged, with carry_update_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 2 | Operation code: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| amt_from_reg_i | input | 1 | 1 takes the amount from reg_amt_i, 0 from imm_amt_i |
| imm_amt_i | input | 5 | Immediate amount field |
| reg_amt_i | input | 32 | Register word whose low byte is the amount |
| operand_i | input | 32 | Value to shift |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | New carry, or carry_i when not updated |
| carry_update_o | output | 1 | High when the carry flag must take carry_o |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result bit 31 |

## Verification
Some invariants are checked by assertions on every input combination. Logical right shifts always clear bit 31. A rotation keeps the number of set bits. An arithmetic shift keeps the sign bit. Oversized logical shifts return zero. The carry passes through whenever carry_update_o is low. The exact choice of carry bit, and the distinct rules at amounts 0, 32 and above 32, can only be shown by the bench. It sweeps every register amount from 0 to 255 and every immediate field for each operation, over random and directed operands, and compares each result against its own model.

// File: rtl/shf_pkg.sv
// Package: shared operation encoding and default widths for the shifter.
// Assumes the data width is a power of two so rotation wraps cleanly.
package shf_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned IMM_AMT_W = 5;
    localparam int unsigned REG_AMT_W = 8;

    typedef enum logic [1:0] {
        OP_SHL  = 2'd0,
        OP_SHR  = 2'd1,
        OP_SAR  = 2'd2,
        OP_ROTR = 2'd3
    } shift_op_e;
endpackage

// File: rtl/shf_amount_decode.sv
// Amount decoder: picks the amount source and classifies the amount into
// no-change, in-range, exactly-width and beyond-width cases.
// Assumes REG_AMT_W > IMM_AMT_W and that DATA_W fits in REG_AMT_W bits.
module shf_amount_decode
    import shf_pkg::*;
#(
    parameter int unsigned W     = DATA_W,
    parameter int unsigned IMM_W = IMM_AMT_W,
    parameter int unsigned REG_W = REG_AMT_W
) (
    input  shift_op_e             op,
    input  logic                  use_reg,
    input  logic [IMM_W-1:0]      imm_amt,
    input  logic [REG_W-1:0]      reg_amt,
    output logic                  no_change,
    output logic                  beyond,
    output logic                  exact,
    output logic [$clog2(W)-1:0]  low_amt
);
    localparam int unsigned AW = $clog2(W);
    localparam logic [REG_W:0] WIDTH_AMT = (REG_W+1)'(W);

    logic [REG_W-1:0] amt_raw;
    logic             amt_zero;
    logic             is_rot;

    // Select the active amount source, zero-extending the immediate field.
    always_comb begin
        amt_raw = use_reg ? reg_amt : {{(REG_W-IMM_W){1'b0}}, imm_amt};
        amt_zero = (amt_raw == '0);
        is_rot   = (op == OP_ROTR);
        low_amt  = amt_raw[AW-1:0];
    end

    // Classify the amount into the cases that carry distinct rules.
    always_comb begin
        no_change = 1'b0;
        beyond    = 1'b0;
        exact     = 1'b0;
        if (use_reg) begin
            no_change = amt_zero;
            if (!is_rot) begin
                beyond = ({1'b0, amt_raw} >= WIDTH_AMT);
                exact  = ({1'b0, amt_raw} == WIDTH_AMT);
            end
        end else if (amt_zero) begin
            // Immediate zero: plain move for left and rotate, full width for right shifts.
            if (op == OP_SHL || is_rot) begin
                no_change = 1'b1;
            end else begin
                beyond = 1'b1;
                exact  = 1'b1;
            end
        end
    end

    // Decoded cases must be mutually consistent (R11).
    always_comb begin
        if (no_change) begin
            p_nochange_not_beyond_r11: assert (!beyond && !exact)
                else $error("no-change amount also marked beyond width");
        end
        if (exact) begin
            p_exact_is_beyond_r6: assert (beyond)
                else $error("exact-width amount not marked beyond");
        end
    end
endmodule

// File: rtl/shf_rotator.sv
// Logarithmic right rotator: one 2:1 stage per amount bit.
// Assumes W is a power of two; amount is taken modulo W.
module shf_rotator #(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [0:AW];

    assign stage[0] = din;

    // Each stage rotates right by 2**k when amount bit k is set.
    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int unsigned STEP = 1 << k;
        assign stage[k+1] = amt[k]
            ? {stage[k][STEP-1:0], stage[k][W-1:STEP]}
            : stage[k];
    end

    assign dout = stage[AW];

    // Rotation keeps the number of set bits (R9).
    always_comb begin
        p_rotate_keeps_ones_r9: assert ($countones(dout) == $countones(din))
            else $error("rotator changed population count");
    end
endmodule

// File: rtl/shf_core.sv
// Shift core: reuses one right rotator for all four operations. Left shifts
// rotate by the negated amount; masks clear or sign-fill the wrapped bits.
// The last bit shifted out lands at bit W-1 (right) or bit 0 (left).
module shf_core
    import shf_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  shift_op_e             op,
    input  logic [W-1:0]          operand,
    input  logic [$clog2(W)-1:0]  low_amt,
    input  logic                  no_change,
    input  logic                  beyond,
    input  logic                  exact,
    input  logic                  carry_in,
    output logic [W-1:0]          result,
    output logic                  carry_out,
    output logic                  carry_upd
);
    localparam int unsigned AW = $clog2(W);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [AW-1:0] rot_amt;
    logic [W-1:0]  rotated;
    logic [W-1:0]  mask_right;
    logic [W-1:0]  mask_left;
    logic          sign;
    logic          is_left;

    // Left shift by n equals right rotate by W-n, which is -n modulo W.
    always_comb begin
        is_left = (op == OP_SHL);
        rot_amt = is_left ? (AW'(0) - low_amt) : low_amt;
        sign    = operand[W-1];
    end

    shf_rotator #(.W(W), .AW(AW)) u_rot (
        .din  (operand),
        .amt  (rot_amt),
        .dout (rotated)
    );

    // Masks that keep only bits that did not wrap around.
    always_comb begin
        mask_right = ALL_ONES >> low_amt;
        mask_left  = ALL_ONES << low_amt;
    end

    // Final result and carry per operation and amount class.
    always_comb begin
        result    = operand;
        carry_out = carry_in;
        carry_upd = 1'b0;
        if (!no_change) begin
            carry_upd = 1'b1;
            unique case (op)
                OP_SHL: begin
                    if (beyond) begin
                        result    = '0;
                        carry_out = exact & operand[0];
                    end else begin
                        result    = rotated & mask_left;
                        carry_out = rotated[0];
                    end
                end
                OP_SHR: begin
                    if (beyond) begin
                        result    = '0;
                        carry_out = exact & sign;
                    end else begin
                        result    = rotated & mask_right;
                        carry_out = rotated[W-1];
                    end
                end
                OP_SAR: begin
                    if (beyond) begin
                        result    = {W{sign}};
                        carry_out = sign;
                    end else begin
                        result    = (rotated & mask_right) | ({W{sign}} & ~mask_right);
                        carry_out = rotated[W-1];
                    end
                end
                default: begin
                    // Rotate: zero low bits give rotated == operand, carry = bit W-1.
                    result    = rotated;
                    carry_out = rotated[W-1];
                end
            endcase
        end
    end

    // Output invariants per operation (R1, R6, R8).
    always_comb begin
        if (carry_upd && op == OP_SHR) begin
            p_shr_msb_clear_r1: assert (result[W-1] == 1'b0)
                else $error("logical right shift left bit W-1 set");
        end
        if (carry_upd && op == OP_SAR) begin
            p_sar_keeps_sign_r8: assert (result[W-1] == operand[W-1])
                else $error("arithmetic shift changed the sign bit");
        end
        if (beyond && (op == OP_SHL || op == OP_SHR)) begin
            p_wide_logical_zero_r6: assert (result == '0)
                else $error("logical shift by width or more not zero");
        end
    end
endmodule

// File: rtl/shf_flags.sv
// Result flags: zero and negative indications derived from the shifted value.
module shf_flags #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] value,
    output logic         is_zero,
    output logic         is_neg
);
    // Reduce the value to its zero and sign indications.
    always_comb begin
        is_zero = (value == '0);
        is_neg  = value[W-1];
    end
endmodule

// File: rtl/shifter_carry_unit.sv
// Top: combinational 32-bit shifter with carry-out, carry-update strobe and
// zero/negative flags. No clock or reset: the caller registers results.
// Assumes op_i is one of the four codes in shf_pkg::shift_op_e.
module shifter_carry_unit
    import shf_pkg::*;
#(
    parameter int unsigned W     = DATA_W,
    parameter int unsigned IMM_W = IMM_AMT_W,
    parameter int unsigned REG_W = REG_AMT_W
) (
    input  logic [1:0]       op_i,
    input  logic             amt_from_reg_i,
    input  logic [IMM_W-1:0] imm_amt_i,
    input  logic [W-1:0]     reg_amt_i,
    input  logic [W-1:0]     operand_i,
    input  logic             carry_i,
    output logic [W-1:0]     result_o,
    output logic             carry_o,
    output logic             carry_update_o,
    output logic             zero_o,
    output logic             neg_o
);
    localparam int unsigned AW = $clog2(W);

    shift_op_e     op;
    logic          no_change;
    logic          beyond;
    logic          exact;
    logic [AW-1:0] low_amt;
    logic          upper_amt_unused;

    // Cast the raw code and mark the ignored register bits as unused.
    always_comb begin
        op               = shift_op_e'(op_i);
        upper_amt_unused = ^reg_amt_i[W-1:REG_W];
    end

    shf_amount_decode #(.W(W), .IMM_W(IMM_W), .REG_W(REG_W)) u_dec (
        .op        (op),
        .use_reg   (amt_from_reg_i),
        .imm_amt   (imm_amt_i),
        .reg_amt   (reg_amt_i[REG_W-1:0]),
        .no_change (no_change),
        .beyond    (beyond),
        .exact     (exact),
        .low_amt   (low_amt)
    );

    shf_core #(.W(W)) u_core (
        .op        (op),
        .operand   (operand_i),
        .low_amt   (low_amt),
        .no_change (no_change),
        .beyond    (beyond),
        .exact     (exact),
        .carry_in  (carry_i),
        .result    (result_o),
        .carry_out (carry_o),
        .carry_upd (carry_update_o)
    );

    shf_flags #(.W(W)) u_flags (
        .value   (result_o),
        .is_zero (zero_o),
        .is_neg  (neg_o)
    );

    // Port-level checks: held carry and unchanged value (R11, R5).
    always_comb begin
        if (!carry_update_o) begin
            p_carry_held_r11: assert (carry_o == carry_i)
                else $error("carry changed while update strobe low");
            p_value_held_r5: assert (result_o == operand_i)
                else $error("value changed while update strobe low");
        end
        if (amt_from_reg_i && reg_amt_i[REG_W-1:0] == '0) begin
            p_reg_zero_no_update_r5: assert (!carry_update_o)
                else $error("register amount zero raised update strobe");
        end
    end
endmodule

// File: tb/tb_shifter_carry_unit.sv
module tb_shifter_carry_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_i = '0;
    logic        amt_from_reg_i = 1'b0;
    logic [4:0]  imm_amt_i = '0;
    logic [31:0] reg_amt_i = '0;
    logic [31:0] operand_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic        carry_o, carry_update_o, zero_o, neg_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    shifter_carry_unit dut (
        .op_i(op_i), .amt_from_reg_i(amt_from_reg_i), .imm_amt_i(imm_amt_i),
        .reg_amt_i(reg_amt_i), .operand_i(operand_i), .carry_i(carry_i),
        .result_o(result_o), .carry_o(carry_o), .carry_update_o(carry_update_o),
        .zero_o(zero_o), .neg_o(neg_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Independent model built from the requirements.
    function automatic void model(input int op, input bit use_reg, input int imm,
                                  input logic [31:0] rw, input logic [31:0] a, input bit cin,
                                  output logic [31:0] res, output bit cout,
                                  output bit upd, output string tag);
        int n;
        n = use_reg ? int'(rw[7:0]) : imm;
        res = a; cout = cin; upd = 1'b1; tag = "R1";
        if (n == 0 && (use_reg || op == 0 || op == 3)) begin
            upd = 1'b0;
            tag = use_reg ? "R5" : (op == 0 ? "R2" : "R12");
        end else if (op == 3) begin
            int r;
            r = n % 32;
            tag = use_reg ? "R9" : "R12";
            if (r == 0) begin
                res = a; cout = a[31];
            end else begin
                res = (a >> r) | (a << (32 - r)); cout = a[r-1];
            end
        end else if (!use_reg && n == 0) begin
            tag = (op == 1) ? "R3" : "R4";
            res = (op == 2 && a[31]) ? 32'hFFFF_FFFF : 32'h0;
            cout = a[31];
        end else if (n < 32) begin
            if (op == 0) begin res = a << n; cout = a[32-n]; end
            else if (op == 1) begin res = a >> n; cout = a[n-1]; end
            else begin res = 32'($signed(a) >>> n); cout = a[n-1]; end
        end else begin
            tag = (op == 0) ? "R6" : (op == 1) ? "R7" : "R8";
            if (op == 2) begin
                res = a[31] ? 32'hFFFF_FFFF : 32'h0; cout = a[31];
            end else begin
                res = 32'h0;
                cout = (n == 32) ? (op == 0 ? a[0] : a[31]) : 1'b0;
            end
        end
    endfunction

    task automatic apply(input int op, input bit use_reg, input int imm,
                         input logic [31:0] rw, input logic [31:0] a, input bit cin);
        logic [31:0] er; bit ec, eu; string tag;
        @(posedge clk);
        op_i = 2'(op); amt_from_reg_i = use_reg; imm_amt_i = 5'(imm);
        reg_amt_i = rw; operand_i = a; carry_i = cin;
        @(negedge clk);
        model(op, use_reg, imm, rw, a, cin, er, ec, eu, tag);
        check(tag, "result", result_o, er);
        check(tag, "carry", {31'b0, carry_o}, {31'b0, ec});
        check(eu ? tag : "R11", "carry_update", {31'b0, carry_update_o}, {31'b0, eu});
        check("R10", "zero", {31'b0, zero_o}, {31'b0, er == 32'h0});
        check("R10", "neg", {31'b0, neg_o}, {31'b0, er[31]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [4];
        void'($urandom(32'd20240611));
        pats[0] = 32'h8000_0001; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h0000_0000; pats[3] = 32'h7FFF_FFFE;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle inputs: immediate left by 0 holds operand 0 (R2, R10).
        check("R2", "idle result", result_o, 32'h0);
        check("R10", "idle zero", {31'b0, zero_o}, 32'h1);

        // Directed corners at the amount boundaries (R3, R4, R6, R7, R8, R9).
        for (int p = 0; p < 4; p++) begin
            for (int op = 0; op < 4; op++) begin
                apply(op, 1'b0, 0, 32'h0, pats[p], 1'b1);
                apply(op, 1'b0, 0, 32'h0, pats[p], 1'b0);
                apply(op, 1'b1, 0, 32'h0, pats[p], 1'b1);
                apply(op, 1'b1, 0, 32'h0000_0020, pats[p], 1'b0);
                apply(op, 1'b1, 0, 32'h0000_0021, pats[p], 1'b1);
                apply(op, 1'b1, 0, 32'h0000_0040, pats[p], 1'b0);
                apply(op, 1'b1, 0, 32'h0000_00FF, pats[p], 1'b1);
            end
        end

        // Register sweep 0..255 with random upper bits (R5) and operands.
        for (int op = 0; op < 4; op++) begin
            for (int n = 0; n < 256; n++) begin
                logic [31:0] rw;
                rw = {$urandom() & 32'hFFFF_FF00} | 32'(n);
                apply(op, 1'b1, 0, rw, $urandom(), 1'($urandom()));
            end
        end

        // Immediate sweep 0..31 for every operation (R1, R12).
        for (int op = 0; op < 4; op++) begin
            for (int n = 0; n < 32; n++) begin
                apply(op, 1'b0, n, $urandom(), $urandom(), 1'($urandom()));
                apply(op, 1'b0, n, $urandom(), pats[n % 4], 1'($urandom()));
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule